// File: doc/BRIEF.md
# Converter Conversion Sequencer with Control Register

This block is the digital side of a successive-approximation converter. Software sees one 8-bit control and status register through a plain write strobe, write-data bus and always-valid read-data bus. A prescaler divides the system clock down to a converter tick. A sequencer counts these ticks for each conversion, and at the final tick it stores a 10-bit sample taken from an input port. It also raises a completion flag that can request an interrupt.

A conversion starts when software writes the start bit while the converter is enabled. The first conversion after enabling runs the long initialization length, and every later one runs the short length. In free-run mode each completion retriggers the next conversion. Clearing the enable bit stops everything at once. The flag is cleared either by writing a one to its bit or by an acknowledge pulse from the interrupt controller.

Top module: `adc_sar_sequencer`

## Requirements
- R1: After reset the register reads 0x00, the result reads 0 and the interrupt request is low.
- R2: Register bit 7 is enable, bit 6 is start/busy, bit 5 is free-run, bit 4 is the completion flag, bit 3 is interrupt enable and bits 2:0 are the prescaler select. Enable, free-run, interrupt enable and prescaler select read back the value last written.
- R3: Select values 0 and 1 divide by 2, and a value n from 2 to 7 divides by 2^n. Converter ticks fall on the system clock edges k·ratio (k ≥ 1) counted from the edge that wrote enable to one. A conversion started at edge S ends on the N-th tick after S.
- R4: The first conversion after enable lasts 25 ticks. This holds whether start is written in the same write as enable or in a later write.
- R5: Every later conversion lasts 13 ticks. After enable is cleared and set again, the next conversion lasts 25 ticks again.
- R6: Bit 6 reads 1 while a conversion runs and returns to 0 when it ends. Writing 0 to it has no effect. Writing 1 has no effect while a conversion is running or when the same write leaves enable at 0.
- R7: On the edge that ends a conversion, the result register takes the value of the sample input and the flag is set. The result then holds until the next completion.
- R8: Writing 1 to bit 4 clears the flag, and writing 0 to it leaves the flag unchanged. A high acknowledge input on a clock edge also clears the flag.
- R9: If a completion falls on the same edge as a flag clear (by acknowledge or by write), the flag ends up set.
- R10: The interrupt request is high exactly when the flag, the interrupt-enable bit and the global interrupt enable input are all high.
- R11: With free-run set, each completion starts a 13-tick conversion at once. If free-run is cleared during a conversion, the chain stops after that conversion ends.
- R12: A write that clears enable ends a running conversion on that edge. The result is not written, the flag is not set, busy reads 0 and the prescaler phase restarts at the next enable.
- R13: A disabling write that lands on the edge that would have ended a conversion still aborts it, with no result update and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csrWrEn | input | 1 | Register write strobe |
| csrWrData | input | 8 | Register write data |
| csrRdData | output | 8 | Register read data |
| sampleIn | input | 10 | Converted sample from the analog front end |
| irqAck | input | 1 | Interrupt acknowledge pulse, clears the flag |
| globalIrqEn | input | 1 | Global interrupt enable |
| irqReq | output | 1 | Interrupt request |
| result | output | 10 | Last completed conversion result |

## Verification
Two events can land on the same clock edge: the end of a conversion, and either a flag clear or a disabling write. The bench computes the exact completion edge from the enable edge, the divide ratio and the length. It then schedules the acknowledge pulse, the write-one-to-clear or the disable write on that edge. Flag and result are judged after it: the flag must survive a clear, while a disable must leave both the flag and the result untouched.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CSR_W       = 8;
  localparam int BIT_ENABLE  = 7;
  localparam int BIT_START   = 6;
  localparam int BIT_FREERUN = 5;
  localparam int BIT_FLAG    = 4;
  localparam int BIT_IRQEN   = 3;
  localparam int PSEL_W      = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic prescClr;  // hold prescaler at zero
    logic cycClr;    // clear tick counter
    logic cycInc;    // count one converter tick
    logic capture;   // load result from sample input
    logic longLen;   // current conversion uses the initialization length
  } seqStrobe_t;

  // log2 of the divide ratio selected by the prescaler field
  function automatic int divShift(input logic [PSEL_W-1:0] sel);
    return (sel < PSEL_W'(2)) ? 1 : int'(sel);
  endfunction
endpackage

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int RESULT_W   = 10,
  parameter int NORMAL_LEN = 13,
  parameter int INIT_LEN   = 25
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [PSEL_W-1:0]   prescSel,
  input  logic [RESULT_W-1:0] sampleIn,
  output logic                tick,
  output logic                lastCycle,
  output logic [RESULT_W-1:0] result
);
  localparam int PRESC_W = (1 << PSEL_W) - 1;
  localparam int CYC_W   = $clog2(INIT_LEN);
  localparam logic [CYC_W-1:0] NORMAL_LAST = CYC_W'(NORMAL_LEN - 1);
  localparam logic [CYC_W-1:0] INIT_LAST   = CYC_W'(INIT_LEN - 1);

  logic [PRESC_W-1:0] prescCnt;
  logic [PRESC_W-1:0] divMask;
  logic [CYC_W-1:0]   cycCnt;

  always_comb divMask = PRESC_W'((1 << divShift(prescSel)) - 1);

  // free-running divider, held at zero while the converter is off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                prescCnt <= '0;
    else if (strobe.prescClr) prescCnt <= '0;
    else                      prescCnt <= prescCnt + PRESC_W'(1);
  end

  assign tick = !strobe.prescClr && ((prescCnt | ~divMask) == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cycCnt <= '0;
    else if (strobe.cycClr) cycCnt <= '0;
    else if (strobe.cycInc) cycCnt <= cycCnt + CYC_W'(1);
  end

  assign lastCycle = (cycCnt == (strobe.longLen ? INIT_LAST : NORMAL_LAST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               result <= '0;
    else if (strobe.capture) result <= sampleIn;
  end
endmodule

// File: rtl/adc_seq_control.sv
module adc_seq_control
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CSR_W-1:0]  wrData,
  input  logic              irqAck,
  input  logic              globalIrqEn,
  input  logic              tick,
  input  logic              lastCycle,
  output seqStrobe_t        strobe,
  output logic [PSEL_W-1:0] prescSel,
  output logic [CSR_W-1:0]  csrValue,
  output logic              irqReq
);
  logic enableQ, busyQ, freeRunQ, flagQ, irqEnQ, firstQ;
  logic [PSEL_W-1:0] prescQ;
  logic disableWr, startReq, done, flagClr;

  always_comb begin
    disableWr = wrEn && !wrData[BIT_ENABLE];
    startReq  = wrEn && wrData[BIT_ENABLE] && wrData[BIT_START] && !busyQ;
    done      = busyQ && tick && lastCycle && !disableWr;
    flagClr   = (wrEn && wrData[BIT_FLAG]) || irqAck;
  end

  always_comb begin
    strobe.prescClr = !enableQ;
    strobe.cycClr   = !busyQ || done;
    strobe.cycInc   = busyQ && tick;
    strobe.capture  = done;
    strobe.longLen  = firstQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      freeRunQ <= 1'b0;
      irqEnQ   <= 1'b0;
      prescQ   <= '0;
    end else if (wrEn) begin
      enableQ  <= wrData[BIT_ENABLE];
      freeRunQ <= wrData[BIT_FREERUN];
      irqEnQ   <= wrData[BIT_IRQEN];
      prescQ   <= wrData[PSEL_W-1:0];
    end
  end

  // a completion outranks a clear on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        flagQ <= 1'b0;
    else if (done)    flagQ <= 1'b1;
    else if (flagClr) flagQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busyQ <= 1'b0;
    else if (disableWr) busyQ <= 1'b0;
    else if (startReq)  busyQ <= 1'b1;
    else if (done)      busyQ <= freeRunQ;
  end

  // initialization length pending until the first completion after enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      firstQ <= 1'b1;
    else if (disableWr || !enableQ) firstQ <= 1'b1;
    else if (done)                  firstQ <= 1'b0;
  end

  assign prescSel = prescQ;
  assign csrValue = {enableQ, busyQ, freeRunQ, flagQ, irqEnQ, prescQ};
  assign irqReq   = flagQ && irqEnQ && globalIrqEn;
endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer
  import adc_seq_pkg::*;
#(
  parameter int RESULT_W   = 10,
  parameter int NORMAL_LEN = 13,
  parameter int INIT_LEN   = 25
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csrWrEn,
  input  logic [CSR_W-1:0]    csrWrData,
  output logic [CSR_W-1:0]    csrRdData,
  input  logic [RESULT_W-1:0] sampleIn,
  input  logic                irqAck,
  input  logic                globalIrqEn,
  output logic                irqReq,
  output logic [RESULT_W-1:0] result
);
  seqStrobe_t        strobe;
  logic [PSEL_W-1:0] prescSel;
  logic              tick;
  logic              lastCycle;

  adc_seq_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (csrWrEn),
    .wrData     (csrWrData),
    .irqAck     (irqAck),
    .globalIrqEn(globalIrqEn),
    .tick       (tick),
    .lastCycle  (lastCycle),
    .strobe     (strobe),
    .prescSel   (prescSel),
    .csrValue   (csrRdData),
    .irqReq     (irqReq)
  );

  adc_seq_datapath #(
    .RESULT_W  (RESULT_W),
    .NORMAL_LEN(NORMAL_LEN),
    .INIT_LEN  (INIT_LEN)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .prescSel (prescSel),
    .sampleIn (sampleIn),
    .tick     (tick),
    .lastCycle(lastCycle),
    .result   (result)
  );
endmodule

// File: rtl/adc_sar_sequencer_checker.sv
module adc_sar_sequencer_checker #(
  parameter int RESULT_W = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEnable,
  input logic                wrEnBit,
  input logic                wrStartBit,
  input logic                wrFlagBit,
  input logic                rdEnable,
  input logic                rdBusy,
  input logic                rdFlag,
  input logic                irqAck,
  input logic                globalIrqEn,
  input logic                irqReq,
  input logic [RESULT_W-1:0] result
);
  assert_busy_needs_enable_R12: assert property (@(posedge clk) disable iff (!rstN)
    rdBusy |-> rdEnable);

  assert_result_with_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> rdFlag);

  assert_start_zero_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnable && !wrStartBit && !rdBusy) |=> !rdBusy);

  assert_flag_write_zero_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnable && !wrFlagBit && rdFlag && !irqAck) |=> rdFlag);

  assert_irq_needs_global_R10: assert property (@(posedge clk) disable iff (!rstN)
    !globalIrqEn |-> !irqReq);

  assert_disable_aborts_R12: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnable && !wrEnBit) |=> (!rdBusy && $stable(result)));

  assert_disable_no_flag_R13: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnable && !wrEnBit && !rdFlag) |=> !rdFlag);
endmodule

bind adc_sar_sequencer adc_sar_sequencer_checker #(.RESULT_W(RESULT_W)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .wrEnable   (csrWrEn),
  .wrEnBit    (csrWrData[7]),
  .wrStartBit (csrWrData[6]),
  .wrFlagBit  (csrWrData[4]),
  .rdEnable   (csrRdData[7]),
  .rdBusy     (csrRdData[6]),
  .rdFlag     (csrRdData[4]),
  .irqAck     (irqAck),
  .globalIrqEn(globalIrqEn),
  .irqReq     (irqReq),
  .result     (result)
);

// File: tb/test_adc_sar_sequencer.sv
`timescale 1ns/1ps
module test_adc_sar_sequencer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csrWrEn = 1'b0;
  logic [7:0] csrWrData = 8'h00;
  logic [7:0] csrRdData;
  logic [9:0] sampleIn = 10'h000;
  logic       irqAck = 1'b0;
  logic       globalIrqEn = 1'b1;
  logic       irqReq;
  logic [9:0] result;

  int checks = 0;
  int errors = 0;
  int edgeNo = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) edgeNo <= edgeNo + 1;

  adc_sar_sequencer i_adc_sar_sequencer (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .csrRdData(csrRdData), .sampleIn(sampleIn), .irqAck(irqAck),
    .globalIrqEn(globalIrqEn), .irqReq(irqReq), .result(result)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edgeNo);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // called at a negedge; returns at the next negedge with the write edge number
  task automatic wrReg(input logic [7:0] d, output int wEdge);
    csrWrEn = 1'b1;
    csrWrData = d;
    @(negedge clk);
    csrWrEn = 1'b0;
    wEdge = edgeNo;
  endtask

  task automatic waitEdge(input int target);
    while (edgeNo < target) @(negedge clk);
  endtask

  function automatic int ratioOf(input int s);
    return (s < 2) ? 2 : (1 << s);
  endfunction

  function automatic int doneEdge(input int enEdge, input int stEdge, input int r, input int len);
    return enEdge + ((stEdge - enEdge) / r + len) * r;
  endfunction

  function automatic int busyOf();  return int'(csrRdData[6]); endfunction
  function automatic int flagOf();  return int'(csrRdData[4]); endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int en, st, d, w, oldRes;
    int vA, vB;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 register", int'(csrRdData), 0);
    check("R1 result", int'(result), 0);
    check("R1 irq", int'(irqReq), 0);

    // sweep all prescaler settings: first and second conversion timing
    for (int s = 0; s < 8; s++) begin
      int r;
      r = ratioOf(s);
      wrReg(8'h10, w);
      wrReg(8'hC0 | 8'(s), en);
      d = en + 25 * r;
      vA = (s * 97 + 5) & 1023;
      waitEdge(d - 1);
      check("R4 busy before init end", busyOf(), 1);
      check("R3 flag before end", flagOf(), 0);
      sampleIn = 10'(vA);
      waitEdge(d);
      check("R4 busy after init end", busyOf(), 0);
      check("R7 flag set", flagOf(), 1);
      check("R7 result", int'(result), vA);
      sampleIn = 10'(~vA);
      waitEdge(d + 3 + s);
      wrReg(8'hC0 | 8'(s), st);
      check("R8 write zero keeps flag", flagOf(), 1);
      check("R2 readback", int'(csrRdData & 8'hAF), 8'h80 | s);
      d = doneEdge(en, st, r, 13);
      vB = (s * 211 + 77) & 1023;
      waitEdge(d - 1);
      check("R5 busy before normal end", busyOf(), 1);
      check("R3 result held", int'(result), vA);
      sampleIn = 10'(vB);
      waitEdge(d);
      check("R5 busy after normal end", busyOf(), 0);
      check("R7 result second", int'(result), vB);
      wrReg(8'h90 | 8'(s), w);
      check("R8 write one clears", flagOf(), 0);
    end

    // start handling (ratio 2)
    wrReg(8'h00, w);
    oldRes = int'(result);
    wrReg(8'h40, w);
    check("R6 start while disabled", busyOf(), 0);
    waitEdge(w + 80);
    check("R6 no result while disabled", int'(result), oldRes);
    wrReg(8'h80, en);
    wrReg(8'h80, w);
    check("R6 start zero no effect", busyOf(), 0);
    waitEdge(en + 5);
    wrReg(8'hC0, st);
    check("R6 busy reads one", busyOf(), 1);
    d = doneEdge(en, st, 2, 25);
    waitEdge(st + 10);
    wrReg(8'hC0, w);
    waitEdge(d - 1);
    check("R4 late start long length", busyOf(), 1);
    sampleIn = 10'd321;
    waitEdge(d);
    check("R6 busy clears", busyOf(), 0);
    check("R7 result", int'(result), 321);

    // acknowledge and coincidence with completion
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
    check("R8 ack clears", flagOf(), 0);
    wrReg(8'hC0, st);
    d = doneEdge(en, st, 2, 13);
    waitEdge(d - 1);
    irqAck = 1'b1;
    waitEdge(d);
    irqAck = 1'b0;
    check("R9 ack vs completion", flagOf(), 1);
    wrReg(8'hC0, st);
    d = doneEdge(en, st, 2, 13);
    waitEdge(d - 1);
    csrWrEn = 1'b1; csrWrData = 8'h90;
    waitEdge(d);
    csrWrEn = 1'b0;
    check("R9 write clear vs completion", flagOf(), 1);
    check("R9 busy", busyOf(), 0);

    // interrupt request combinations
    globalIrqEn = 1'b0;
    wrReg(8'h88, w);
    check("R10 global off", int'(irqReq), 0);
    globalIrqEn = 1'b1;
    @(negedge clk);
    check("R10 all high", int'(irqReq), 1);
    wrReg(8'h80, w);
    check("R10 enable off", int'(irqReq), 0);
    wrReg(8'h88, w);
    check("R10 enable on", int'(irqReq), 1);
    wrReg(8'h98, w);
    check("R10 flag cleared", int'(irqReq), 0);

    // free-run chain
    wrReg(8'h10, w);
    wrReg(8'hE0, en);
    d = en + 50;
    waitEdge(d - 1);
    sampleIn = 10'd11;
    waitEdge(d);
    check("R11 first result", int'(result), 11);
    check("R11 still busy", busyOf(), 1);
    waitEdge(d + 25);
    sampleIn = 10'd22;
    waitEdge(d + 26);
    check("R11 second result", int'(result), 22);
    check("R11 restarted", busyOf(), 1);
    wrReg(8'h80, w);
    waitEdge(d + 51);
    check("R11 running after clear", busyOf(), 1);
    sampleIn = 10'd33;
    waitEdge(d + 52);
    check("R11 last result", int'(result), 33);
    check("R11 chain stopped", busyOf(), 0);
    waitEdge(d + 90);
    check("R11 stays idle", busyOf(), 0);

    // abort
    wrReg(8'h10, w);
    oldRes = int'(result);
    wrReg(8'hC0, en);
    sampleIn = 10'd444;
    waitEdge(en + 20);
    wrReg(8'h10, w);
    check("R12 busy cleared", busyOf(), 0);
    check("R12 enable cleared", int'(csrRdData[7]), 0);
    waitEdge(en + 70);
    check("R12 no result", int'(result), oldRes);
    check("R12 no flag", flagOf(), 0);
    wrReg(8'hC0, en);
    waitEdge(en + 49);
    check("R5 re-enable long length", busyOf(), 1);
    sampleIn = 10'd555;
    waitEdge(en + 50);
    check("R5 re-enable completes", busyOf(), 0);
    check("R5 result", int'(result), 555);

    // disable on the completing edge
    wrReg(8'h10, w);
    oldRes = int'(result);
    wrReg(8'hC0, en);
    d = en + 50;
    waitEdge(d - 1);
    sampleIn = 10'd666;
    csrWrEn = 1'b1; csrWrData = 8'h00;
    waitEdge(d);
    csrWrEn = 1'b0;
    check("R13 no flag", flagOf(), 0);
    check("R13 no result", int'(result), oldRes);
    check("R13 busy", busyOf(), 0);

    finishRun();
  end
endmodule